// File: doc/BRIEF.md
# Buffered Compare-Match PWM Timer

A single up-counting timer channel for pulse-width modulation. The counter advances on cycles where the channel is running and an external count tick is present. Two compare registers shape a waveform on the timer pin. A match against the period compare (B) clears the counter, issues an interrupt pulse and drives one output edge. A match against the duty compare (A) drives the opposite edge. A polarity bit selects which edge each compare produces.

The period compare can be written in one of two ways. It can be written straight into the active register, or it can be written into a shadow buffer whose contents move into the active register only when the counter clears on a period match. With the buffer, software can change the period at any time without cutting a cycle short. A small register bus gives write and read access to control, both compares and the counter.

Top module: `cmp_pwm_timer`

## Requirements
- R1: The counter increments by one on a clock edge only when control bit 0 (run) is 1 and `tick_i` is 1; otherwise it holds.
- R2: On an advancing edge where the counter equals the active period compare, the counter becomes 0 instead of incrementing.
- R3: `irq_o` is high for the single cycle that follows each period-match edge, the same cycle in which the counter first reads 0.
- R4: On a period match, `tmr_o` becomes 0 when control bit 2 (invert) is 0 and becomes 1 when invert is 1.
- R5: On an advancing edge where the counter equals compare A, `tmr_o` becomes 1 when invert is 0 and 0 when invert is 1; the counter still increments.
- R6: With control bit 1 (buffer select) at 0, a write to address 2 updates the active period compare at once, and reads of address 2 return it.
- R7: With buffer select at 1, a write to address 2 goes to the shadow buffer and reads of address 2 return the buffer. The active period compare changes only on a period match, and then takes the buffer's value.
- R8: With buffer select at 1, a write to address 2 on the same edge as a period match stores into the buffer. The active compare receives the previous buffer value, so the new value governs only the next period.
- R9: Writes to address 3 (counter) have no effect; reads of address 3 return the current count. Address 0 is control and address 1 is compare A.
- R10: After reset, control reads 0, and `tmr_o` and `irq_o` are 0.
- R11: When compare A and the period compare match on the same edge, the period-match output level wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 compare A, 2 period compare, 3 counter |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| tick_i | input | 1 | Count enable tick |
| irq_o | output | 1 | Period-match interrupt pulse |
| tmr_o | output | 1 | PWM timer output |

## Verification
A wrong active period value shows up as an interrupt at the wrong count. It appears at the first period match after the error, and with buffering at most one period after the buffer is loaded. A stuck or mis-stepped counter can be seen at the counter read address on the very next tick. An edge with the wrong polarity appears on `tmr_o` in the cycle after the match that produced it. A corrupted buffer transfer can be seen in the reads of address 2, and it changes the period one period later.

// File: rtl/cmp_pwm_pkg.sv
package cmp_pwm_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_CMPA = 2'd1,
    REG_CMPB = 2'd2,
    REG_CNT  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic invert;
    logic buf_sel;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmp_pwm_regs.sv
module cmp_pwm_regs
  import cmp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cmp_a_o,
  output logic [CNT_W-1:0]  cmp_b_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_b_q, cmp_b_buf_q;
  logic             wr_ctrl, wr_a, wr_b;

  assign wr_ctrl = we_i && (addr_i == REG_CTRL);
  assign wr_a    = we_i && (addr_i == REG_CMPA);
  assign wr_b    = we_i && (addr_i == REG_CMPB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_a)    cmp_a_q <= wdata_i;
    end
  end

  // active period: buffered transfer on match, else direct write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_b_q     <= '0;
      cmp_b_buf_q <= '0;
    end else begin
      if (load_i && ctrl_q.buf_sel)       cmp_b_q <= cmp_b_buf_q;
      else if (wr_b && !ctrl_q.buf_sel)   cmp_b_q <= wdata_i;
      if (wr_b && ctrl_q.buf_sel)         cmp_b_buf_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o = CNT_W'(ctrl_q);
      REG_CMPA: rdata_o = cmp_a_q;
      REG_CMPB: rdata_o = ctrl_q.buf_sel ? cmp_b_buf_q : cmp_b_q;
      REG_CNT:  rdata_o = cnt_i;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign cmp_a_o = cmp_a_q;
  assign cmp_b_o = cmp_b_q;
endmodule

// File: rtl/cmp_pwm_counter.sv
module cmp_pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_a_o,
  output logic             hit_b_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv     = run_i && tick_i;
  assign hit_b_o = adv && (cnt_q == cmp_b_i);
  assign hit_a_o = adv && (cnt_q == cmp_a_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hit_b_o) cnt_q <= '0;
    else if (adv)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmp_pwm_outgen.sv
module cmp_pwm_outgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic invert_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  output logic irq_o,
  output logic tmr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      tmr_o <= 1'b0;
    end else begin
      irq_o <= hit_b_i;
      // period edge has priority over duty edge
      if (hit_b_i)      tmr_o <= invert_i;
      else if (hit_a_i) tmr_o <= ~invert_i;
    end
  end
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
  import cmp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              tmr_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, cmp_a, cmp_b;
  logic             hit_a, hit_b;

  cmp_pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .cnt_i   (cnt),
    .load_i  (hit_b),
    .rdata_o (bus_rdata_o),
    .ctrl_o  (ctrl),
    .cmp_a_o (cmp_a),
    .cmp_b_o (cmp_b)
  );

  cmp_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl.run),
    .tick_i  (tick_i),
    .cmp_a_i (cmp_a),
    .cmp_b_i (cmp_b),
    .cnt_o   (cnt),
    .hit_a_o (hit_a),
    .hit_b_o (hit_b)
  );

  cmp_pwm_outgen u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .invert_i (ctrl.invert),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .irq_o    (irq_o),
    .tmr_o    (tmr_o)
  );
endmodule

// File: rtl/cmp_pwm_timer_chk.sv
module cmp_pwm_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             tick_i,
  input logic             invert_i,
  input logic             buf_sel_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_b_i,
  input logic             irq_i,
  input logic             tmr_i
);
  logic adv, per_hit;
  assign adv     = run_i && tick_i;
  assign per_hit = adv && (cnt_i == cmp_b_i);

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(cnt_i)) else $error("AST_CNT_HOLD");                          // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !per_hit) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1)) else $error("AST_CNT_STEP"); // R1
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_hit |=> (cnt_i == '0) && irq_i) else $error("AST_CNT_CLEAR");              // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_hit |=> !irq_i) else $error("AST_IRQ_CAUSE");                            // R3
  AST_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_hit |=> tmr_i == $past(invert_i)) else $error("AST_PER_EDGE");            // R4
  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_sel_i && !per_hit) |=> $stable(cmp_b_i)) else $error("AST_BUF_HOLD");    // R7
endmodule

bind cmp_pwm_timer cmp_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (ctrl.run),
  .tick_i    (tick_i),
  .invert_i  (ctrl.invert),
  .buf_sel_i (ctrl.buf_sel),
  .cnt_i     (cnt),
  .cmp_b_i   (cmp_b),
  .irq_i     (irq_o),
  .tmr_i     (tmr_o)
);

// File: tb/cmp_pwm_timer_bench.sv
module cmp_pwm_timer_bench;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         we = 1'b0, tick = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq, tmr;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cmp_pwm_timer u_cmp_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick),
    .irq_o(irq), .tmr_o(tmr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic cyc(input logic t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic t = 1'b0);
    we = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  // tick until a period match has cleared the counter
  task automatic sync_zero();
    int g = 0;
    while (!irq && g < 70000) begin cyc(1'b1); g++; end
    chk("R2 sync", int'(irq), 1);
  endtask

  task automatic t_reset();
    int v;
    rd(2'd0, v);
    chk("R10 ctrl", v, 0);
    chk("R10 tmr", int'(tmr), 0);
    chk("R10 irq", int'(irq), 0);
  endtask

  task automatic t_count();
    int v;
    wr(2'd2, 16'd3);           // direct period
    wr(2'd1, 16'd200);
    wr(2'd0, 16'd1);           // run
    sync_zero();
    repeat (3) cyc(1'b0);
    rd(2'd3, v); chk("R1 hold no tick", v, 0);
    repeat (2) cyc(1'b1);
    rd(2'd3, v); chk("R1 step", v, 2);
    wr(2'd0, 16'd0);
    repeat (2) cyc(1'b1);
    rd(2'd3, v); chk("R1 hold not running", v, 2);
    wr(2'd3, 16'h55);
    rd(2'd3, v); chk("R9 counter write ignored", v, 2);
    wr(2'd0, 16'd1);
  endtask

  task automatic t_period();
    int v;
    wr(2'd2, 16'd5);
    sync_zero();
    repeat (5) cyc(1'b1);
    rd(2'd3, v); chk("R2 at compare", v, 5);
    chk("R3 no irq before match", int'(irq), 0);
    cyc(1'b1);
    rd(2'd3, v); chk("R2 cleared", v, 0);
    chk("R3 irq pulse", int'(irq), 1);
    chk("R4 low inv0", int'(tmr), 0);
    cyc(1'b0);
    chk("R3 irq one cycle", int'(irq), 0);
  endtask

  task automatic t_duty(input logic inv);
    int v;
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd5);
    wr(2'd0, inv ? 16'd5 : 16'd1);
    sync_zero();
    chk(inv ? "R4 high inv1" : "R4 low inv0", int'(tmr), int'(inv));
    repeat (3) cyc(1'b1);
    chk("R5 duty edge", int'(tmr), int'(!inv));
    rd(2'd3, v); chk("R5 counter continues", v, 3);
    repeat (3) cyc(1'b1);
    chk("R4 period edge", int'(tmr), int'(inv));
    chk("R3 irq", int'(irq), 1);
  endtask

  task automatic t_tie();
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd4);
    sync_zero();
    repeat (5) cyc(1'b1);
    chk("R11 tie period wins", int'(tmr), 0);
    chk("R11 irq", int'(irq), 1);
  endtask

  task automatic t_direct();
    int v;
    wr(2'd1, 16'd100);
    wr(2'd2, 16'd7);
    rd(2'd2, v); chk("R6 readback", v, 7);
    sync_zero();
    repeat (8) cyc(1'b1);
    chk("R6 direct period used", int'(irq), 1);
  endtask

  task automatic t_buffer();
    int v;
    // counter at 0, active period 7
    wr(2'd0, 16'd3);           // run + buffer select
    wr(2'd2, 16'd9);
    rd(2'd2, v); chk("R7 reads buffer", v, 9);
    repeat (8) cyc(1'b1);
    chk("R7 old period still active", int'(irq), 1);
    repeat (9) cyc(1'b1);
    rd(2'd3, v); chk("R7 new period not yet", v, 9);
    chk("R7 no early irq", int'(irq), 0);
    // match edge with simultaneous write of 4
    wr(2'd2, 16'd4, 1'b1);
    chk("R8 match on edge", int'(irq), 1);
    rd(2'd2, v); chk("R8 buffer holds write", v, 4);
    repeat (5) cyc(1'b1);
    chk("R8 old buffer period", int'(irq), 0);
    repeat (5) cyc(1'b1);
    chk("R8 clear at 9", int'(irq), 1);
    repeat (5) cyc(1'b1);
    chk("R8 clear at 4", int'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_period();
    t_duty(1'b0);
    t_duty(1'b1);
    t_tie();
    t_direct();
    t_buffer();
    done = 1'b1;
  end

  initial begin
    int c = 0;
    while (!done && c < 190000) begin @(posedge clk); c++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule